// File: doc/BRIEF.md
# Pretrigger Ring-Buffer Capture Controller

This block runs a single-shot recording of a sample stream into a memory window that is used as a ring. It produces the memory write port: address, data and write enable. The memory itself, trigger generation and host readout sit outside the block. Each accepted sample is written at the current write pointer. The pointer wraps to zero once it reaches the programmed window size, so the window is overwritten continuously until a trigger is accepted.

The window size and the number of post-trigger samples are taken from their inputs when `start` is pulsed. The pretrigger part of the window is the size minus the post-trigger count. Trigger detection stays disarmed until that many samples have been written, so every finished record contains history from before the event. Once a trigger is accepted, exactly the post-trigger count of samples is written, counting the trigger sample itself, and the block stops. It then reports the address of the trigger sample and the address of the oldest sample in the ring. The oldest sample is the next address that would have been written.

The controller has five states. IDLE is entered from reset. The transition IDLE→FILL_PRE happens on `start`. FILL_PRE→ARMED happens when the pretrigger count is reached. ARMED→POST happens on a trigger that coincides with a sample, or ARMED→DONE if the post count is one. POST→DONE happens when the post count is reached. A `start` in any state performs the restart transition back to FILL_PRE.

Top module: `pretrig_capture_ctrl`

## Requirements
- R1: When `wr_en` is high, it equals `smp_valid` and the sample is written at `wr_addr` with `wr_data` = `smp_data`. `wr_en` is high only in FILL_PRE, ARMED and POST, and never in a cycle with `start` high. After each write the address advances by one, and it returns to 0 after the value size−1.
- R2: `mem_size` and `post_len` are captured in the cycle `start` is high. A size below 2 is used as 2, and a size above 2^ADDR_W is used as 2^ADDR_W.
- R3: A captured post-trigger count that is 0, or is not less than the effective size, is used as size−1.
- R4: In FILL_PRE, `trig_in` has no effect. `armed` rises after exactly size−post samples have been written since `start`.
- R5: In ARMED, a trigger is accepted only in a cycle where `trig_in` and `smp_valid` are both high. That sample is written and counts as the first post-trigger sample. `trig_in` without `smp_valid` is ignored.
- R6: After an accepted trigger, exactly post samples are written in total, including the trigger sample. The block then enters DONE, where no sample is written.
- R7: In DONE, `done` is 1. `trig_pos` is the address of the trigger sample and `oldest_addr` is (trig_pos+post) mod size. Both values hold while DONE lasts. Outside DONE both read 0.
- R8: A `start` pulse in any state restarts FILL_PRE from address 0 with fresh counts. The sample offered in the `start` cycle is not written.
- R9: After reset the block is in IDLE: `armed`, `done` and `wr_en` are 0, and no sample is written until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin (or restart) a recording |
| mem_size | input | ADDR_W+1 | Ring window size in samples |
| post_len | input | ADDR_W+1 | Samples to record from the trigger on |
| smp_valid | input | 1 | Sample enable pulse |
| smp_data | input | DATA_W | Sample value |
| trig_in | input | 1 | Trigger event |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | DATA_W | Memory write data |
| armed | output | 1 | Trigger detection enabled |
| done | output | 1 | Recording finished |
| trig_pos | output | ADDR_W | Address of the trigger sample (DONE only) |
| oldest_addr | output | ADDR_W | Address of the oldest valid sample (DONE only) |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8, which gives a 16-entry address space. With that size, wrap-around at the full depth and at odd window sizes such as 6 and 10 happens within a few dozen samples. The size clamps on both sides (1 raised to 2, 31 cut to 16) and every post-count clamp can be reached with small input values. A post count of size−1 can be tested at every size used.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_PRE,
        ST_ARMED,
        ST_POST,
        ST_DONE
    } pcap_state_e;

endpackage

// File: rtl/pcap_cfg.sv
module pcap_cfg #(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [ADDR_W:0] size_in,
    input  logic [ADDR_W:0] post_in,
    output logic [ADDR_W:0] size_q,
    output logic [ADDR_W:0] post_q,
    output logic [ADDR_W:0] pre_q
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [ADDR_W:0] DEPTH_V = CNT_W'(1) << ADDR_W;
    localparam logic [ADDR_W:0] MIN_V   = CNT_W'(2);

    logic [ADDR_W:0] size_c;
    logic [ADDR_W:0] post_c;

    always_comb begin
        if (size_in < MIN_V)
            size_c = MIN_V;
        else if (size_in > DEPTH_V)
            size_c = DEPTH_V;
        else
            size_c = size_in;

        if (post_in == '0 || post_in >= size_c)
            post_c = size_c - CNT_W'(1);
        else
            post_c = post_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= MIN_V;
            post_q <= CNT_W'(1);
        end else if (load) begin
            size_q <= size_c;
            post_q <= post_c;
        end
    end

    assign pre_q = size_q - post_q;

endmodule

// File: rtl/pcap_wptr.sv
module pcap_wptr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [ADDR_W:0]   size,
    output logic [ADDR_W-1:0] ptr
);
    localparam int CNT_W = ADDR_W + 1;

    logic at_end;
    assign at_end = ({1'b0, ptr} == size - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (clr)
            ptr <= '0;
        else if (adv)
            ptr <= at_end ? '0 : ptr + ADDR_W'(1);
    end

endmodule

// File: rtl/pcap_cnt.sv
module pcap_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld_one,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (ld_one)
            cnt <= CNT_W'(1);
        else if (inc)
            cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/pretrig_capture_ctrl.sv
module pretrig_capture_ctrl
    import pcap_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   mem_size,
    input  logic [ADDR_W:0]   post_len,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              trig_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              armed,
    output logic              done,
    output logic [ADDR_W-1:0] trig_pos,
    output logic [ADDR_W-1:0] oldest_addr
);
    localparam int CNT_W = ADDR_W + 1;

    pcap_state_e       state, state_nxt;
    logic [ADDR_W:0]   cfg_size, cfg_post, cfg_pre;
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W:0]   cnt;
    logic [ADDR_W-1:0] trig_q;

    logic active, accept, fill_last, trig_hit, post_last;
    logic cnt_clr, cnt_one, cnt_inc;

    pcap_cfg #(.ADDR_W(ADDR_W)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .size_in (mem_size),
        .post_in (post_len),
        .size_q  (cfg_size),
        .post_q  (cfg_post),
        .pre_q   (cfg_pre)
    );

    pcap_wptr #(.ADDR_W(ADDR_W)) i_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .adv   (accept),
        .size  (cfg_size),
        .ptr   (wptr)
    );

    pcap_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .ld_one (cnt_one),
        .inc    (cnt_inc),
        .cnt    (cnt)
    );

    // Qualification of samples and phase events
    always_comb begin
        active    = (state == ST_FILL_PRE) || (state == ST_ARMED) || (state == ST_POST);
        accept    = active && smp_valid && !start;
        fill_last = accept && (state == ST_FILL_PRE) && (cnt + CNT_W'(1) == cfg_pre);
        trig_hit  = accept && (state == ST_ARMED) && trig_in;
        post_last = (accept && (state == ST_POST) && (cnt + CNT_W'(1) == cfg_post))
                 || (trig_hit && cfg_post == CNT_W'(1));
        cnt_clr   = start || fill_last;
        cnt_one   = trig_hit;
        cnt_inc   = accept && !fill_last && !trig_hit;
    end

    // Next-state decision
    always_comb begin
        state_nxt = state;
        if (start) begin
            state_nxt = ST_FILL_PRE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nxt = ST_IDLE;
                ST_FILL_PRE: if (fill_last) state_nxt = ST_ARMED;
                ST_ARMED:    if (trig_hit)  state_nxt = post_last ? ST_DONE : ST_POST;
                ST_POST:     if (post_last) state_nxt = ST_DONE;
                ST_DONE:     state_nxt = ST_DONE;
                default:     state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register and trigger address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            trig_q <= '0;
        end else begin
            state <= state_nxt;
            if (trig_hit)
                trig_q <= wptr;
        end
    end

    // Outputs
    always_comb begin
        wr_en       = accept;
        wr_addr     = wptr;
        wr_data     = smp_data;
        armed       = (state == ST_ARMED);
        done        = (state == ST_DONE);
        trig_pos    = done ? trig_q : '0;
        oldest_addr = done ? wptr : '0;
    end

endmodule

// File: rtl/pcap_chk.sv
module pcap_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              armed,
    input logic              done,
    input logic [ADDR_W-1:0] trig_pos,
    input logic [ADDR_W-1:0] oldest_addr,
    input logic [ADDR_W:0]   cfg_size,
    input logic [ADDR_W:0]   cfg_post
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [ADDR_W:0] DEPTH_V = CNT_W'(1) << ADDR_W;

    logic [ADDR_W-1:0] step_addr;
    assign step_addr = ({1'b0, wr_addr} == cfg_size - CNT_W'(1)) ? '0 : wr_addr + ADDR_W'(1);

    assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < cfg_size));

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !start) |=> (wr_addr == $past(step_addr)));

    assert_size_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size >= CNT_W'(2)) && (cfg_size <= DEPTH_V));

    assert_post_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_post != '0) && (cfg_post < cfg_size));

    assert_no_write_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(trig_pos) && $stable(oldest_addr)));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (wr_addr == '0 && !armed && !done));

    assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed, done}));

endmodule

bind pretrig_capture_ctrl pcap_chk #(.ADDR_W(ADDR_W)) i_pcap_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .armed       (armed),
    .done        (done),
    .trig_pos    (trig_pos),
    .oldest_addr (oldest_addr),
    .cfg_size    (cfg_size),
    .cfg_post    (cfg_post)
);

// File: tb/test_pretrig_capture_ctrl.sv
module test_pretrig_capture_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW:0]   mem_size;
    logic [AW:0]   post_len;
    logic          smp_valid;
    logic [DW-1:0] smp_data;
    logic          trig_in;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          armed;
    logic          done;
    logic [AW-1:0] trig_pos;
    logic [AW-1:0] oldest_addr;

    always #10 clk = ~clk;

    pretrig_capture_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_pretrig_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_size(mem_size),
        .post_len(post_len), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig_in(trig_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .armed(armed), .done(done), .trig_pos(trig_pos), .oldest_addr(oldest_addr)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Reference model: 0 idle, 1 pretrigger fill, 2 armed, 3 post, 4 done
    int m_mode = 0, m_size = 2, m_post = 1, m_ptr = 0, m_n = 0, m_trig = 0;
    int dat = 0;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int eff_size(int s);
        if (s < 2) return 2;
        if (s > DEPTH) return DEPTH;
        return s;
    endfunction

    function automatic int eff_post(int p, int s);
        if (p == 0 || p >= s) return s - 1;
        return p;
    endfunction

    task automatic cyc(bit st, bit v, bit tg);
        bit we;
        @(negedge clk);
        start = st; smp_valid = v; trig_in = tg; smp_data = DW'(dat);
        #1;
        we = v && !st && (m_mode >= 1 && m_mode <= 3);
        check("R1 wr_en", int'(wr_en), int'(we));
        if (we) begin
            check("R1 wr_addr", int'(wr_addr), m_ptr);
            check("R1 wr_data", int'(wr_data), dat % 256);
        end
        check("R4 armed", int'(armed), int'(m_mode == 2));
        check("R6 done", int'(done), int'(m_mode == 4));
        check("R7 trig_pos", int'(trig_pos), (m_mode == 4) ? m_trig : 0);
        check("R7 oldest_addr", int'(oldest_addr), (m_mode == 4) ? m_ptr : 0);
        dat++;
        if (st) begin
            m_size = eff_size(int'(mem_size));
            m_post = eff_post(int'(post_len), m_size);
            m_mode = 1; m_ptr = 0; m_n = 0;
        end else if (we) begin
            if (m_mode == 1) begin
                if (m_n + 1 == m_size - m_post) begin m_mode = 2; m_n = 0; end
                else m_n++;
            end else if (m_mode == 2) begin
                if (tg) begin
                    m_trig = m_ptr;
                    if (m_post == 1) m_mode = 4;
                    else begin m_mode = 3; m_n = 1; end
                end
            end else begin
                if (m_n + 1 == m_post) m_mode = 4;
                else m_n++;
            end
            m_ptr = (m_ptr + 1 == m_size) ? 0 : m_ptr + 1;
        end
    endtask

    task automatic begin_rec(int s, int p);
        mem_size = (AW+1)'(s);
        post_len = (AW+1)'(p);
        cyc(1, 1, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 0; smp_valid = 0; trig_in = 0; smp_data = '0;
        mem_size = '0; post_len = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state, samples ignored before start
        cyc(0, 1, 1);
        cyc(0, 0, 0);
        check("R9 idle armed", int'(armed), 0);
        check("R9 idle done", int'(done), 0);
        check("R9 idle wr_en", int'(wr_en), 0);

        // Scenario A: size 16, post 4 -> 12 pretrigger samples, trigger held high
        begin_rec(16, 4);
        repeat (11) cyc(0, 1, 1);
        cyc(0, 0, 0);
        check("R4 not armed before fill", int'(armed), 0);
        cyc(0, 1, 1);
        cyc(0, 0, 0);
        check("R4 armed after fill", int'(armed), 1);
        cyc(0, 0, 1);
        cyc(0, 0, 0);
        check("R5 trigger without sample ignored", int'(armed), 1);
        cyc(0, 1, 1);
        repeat (3) cyc(0, 1, 0);
        cyc(0, 0, 0);
        check("R6 done after post count", int'(done), 1);
        check("R7 trigger address", int'(trig_pos), 12);
        check("R7 oldest address", int'(oldest_addr), 0);
        repeat (3) cyc(0, 1, 1);
        check("R6 no write in done", int'(wr_en), 0);
        check("R7 oldest holds", int'(oldest_addr), 0);

        // Scenario B: size 10, post 3, gapped samples, wrap before trigger
        begin_rec(10, 3);
        for (int i = 0; i < 14; i++) cyc(0, i[0], 0);
        cyc(0, 0, 0);
        check("R4 armed after 7 gapped writes", int'(armed), 1);
        repeat (4) cyc(0, 1, 0);
        cyc(0, 1, 1);
        cyc(0, 0, 0);
        cyc(0, 1, 0);
        cyc(0, 1, 0);
        cyc(0, 0, 0);
        check("R5 trigger sample address", int'(trig_pos), 1);
        check("R1 oldest after wrap", int'(oldest_addr), 4);

        // Scenario C: post 0 clamps to size-1
        begin_rec(8, 0);
        cyc(0, 1, 1);
        cyc(0, 1, 1);
        repeat (5) cyc(0, 1, 0);
        cyc(0, 0, 0);
        check("R3 zero post not yet done", int'(done), 0);
        cyc(0, 1, 0);
        cyc(0, 0, 0);
        check("R3 zero post done", int'(done), 1);
        check("R3 zero post trigger", int'(trig_pos), 1);

        // Scenario D: post equal to size clamps to size-1
        begin_rec(6, 6);
        cyc(0, 1, 0);
        cyc(0, 1, 1);
        repeat (4) cyc(0, 1, 0);
        cyc(0, 0, 0);
        check("R3 large post done", int'(done), 1);
        check("R3 large post oldest", int'(oldest_addr), 0);

        // Scenario E: size clamps
        begin_rec(1, 1);
        cyc(0, 1, 0);
        cyc(0, 1, 1);
        cyc(0, 0, 0);
        check("R2 size raised to 2", int'(done), 1);
        check("R2 size 2 oldest", int'(oldest_addr), 0);
        begin_rec(31, 15);
        cyc(0, 1, 0);
        cyc(0, 1, 1);
        repeat (14) cyc(0, 1, 0);
        cyc(0, 0, 0);
        check("R2 size cut to depth", int'(done), 1);
        check("R2 depth oldest", int'(oldest_addr), 0);

        // Scenario F: restart during POST
        begin_rec(8, 4);
        repeat (4) cyc(0, 1, 0);
        cyc(0, 1, 1);
        cyc(0, 1, 0);
        cyc(1, 1, 1);
        cyc(0, 0, 0);
        check("R8 restart address", int'(wr_addr), 0);
        check("R8 restart disarmed", int'(armed), 0);
        repeat (4) cyc(0, 1, 0);
        cyc(0, 1, 1);
        repeat (3) cyc(0, 1, 0);
        cyc(0, 0, 0);
        check("R8 record after restart", int'(trig_pos), 4);
        check("R8 oldest after restart", int'(oldest_addr), 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

endmodule